// File: doc/BRIEF.md
# Sliding One-Cycle DFT Phasor Estimator

This block turns a stream of signed 16-bit samples from a single analog channel into the fundamental-frequency phasor of that channel. Samples arrive at a fixed rate locked to the nominal power frequency, sixteen per power cycle. The block correlates the most recent full cycle of samples against a cosine and a sine reference. It reports the real and imaginary parts, scaled so that they are RMS values, together with the squared magnitude. A full-cycle window cancels every harmonic below the Nyquist rate, so only the fundamental remains.

Results are decimated to four per power cycle, so that a slower protection thread downstream receives a fresh phasor on every one of its ticks. One instance serves one channel. A relay front end uses six instances, one per phase voltage and one per phase current. Square root, angle and frequency-tracking correction are left to the consumer.

Top module: `phasor_dft_est`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first result, `phasor_valid_o` is 0 and `re_o`, `im_o` and `mag_sq_o` are all 0.
- R2: With c(k) = round(sqrt(2)·2^14·cos(2πk/16)), the table c(0..4) is 23170, 21407, 16384, 8867, 0. Every other entry follows from even symmetry c(16−k)=c(k) and half-wave symmetry c(k+8)=−c(k). `re_o` is floor(Σ x(k)·c(k) / 16), summed over the last 16 accepted samples.
- R3: `im_o` is floor(Σ x(k)·c((k+4) mod 16) / 16) over the same window, which equals −sqrt(2)/16·Σ x(k)·sin(2πk/16) in units of 2^-14.
- R4: The sample accepted as the j-th since reset (counting from 0) has reference index k = j mod 16, and it replaces the sample accepted 16 acceptances earlier.
- R5: `mag_sq_o` equals `re_o`² + `im_o`² as an unsigned 64-bit value, presented with the same result.
- R6: `phasor_valid_o` is high for exactly one clock, one clock after the rising edge at which the sample with count j mod 4 = 3 is accepted, so there are four results per 16 samples.
- R7: No result is issued before the 16th sample after reset has been accepted.
- R8: Cycles with `sample_valid_i` low leave the window unchanged, and the three outputs hold their values between pulses.
- R9: A constant input gives `re_o` = `im_o` = 0 once the window is full of it.
- R10: Full-scale inputs of −32768 and +32767 produce exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe, one accepted sample per high cycle |
| sample_i | input | 16 | Signed sample |
| phasor_valid_o | output | 1 | One-clock pulse marking a new result |
| re_o | output | 32 | Signed real part, RMS, 14 fractional bits |
| im_o | output | 32 | Signed imaginary part, RMS, 14 fractional bits |
| mag_sq_o | output | 64 | Unsigned squared magnitude, 28 fractional bits |

## Verification
The bench builds the block with its defaults: a 16-sample window, decimation by 4, 16-bit samples and 16-bit coefficients with 14 fractional bits. These values keep the coefficient table small enough to state exactly, so a direct 16-term correlation in the bench predicts every result to the bit. The bench walks DC, fundamental cosine and sine, a third harmonic, single-sample impulses at both full-scale extremes and an alternating Nyquist pattern. Each pattern streams through the sliding window in turn, and every fourth-sample pulse is checked against the direct sum. Gapped and back-to-back strobes, idle cycles with a changing sample, and a reset in mid-stream are then checked for the fill delay and for hold behaviour.

// File: rtl/dft_pkg.sv
package dft_pkg;

  // round(sqrt(2) * 2^frac * cos(2*pi*k/n)), evaluated at elaboration
  function automatic int coef_val(input int k, input int n, input int frac);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(k) / real'(n);
    v   = $sqrt(2.0) * $cos(ang) * real'(1 << frac);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/dft_coef_rom.sv
module dft_coef_rom #(
  parameter int N      = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14,
  localparam int SLOT_W = $clog2(N)
) (
  input  logic        [SLOT_W-1:0] re_idx_i,
  input  logic        [SLOT_W-1:0] im_idx_i,
  output logic signed [COEF_W-1:0] re_coef_o,
  output logic signed [COEF_W-1:0] im_coef_o
);

  logic signed [COEF_W-1:0] rom [N];

  for (genvar k = 0; k < N; k++) begin : g_rom
    localparam int CV = dft_pkg::coef_val(k, N, FRAC);
    assign rom[k] = COEF_W'(CV);
  end

  assign re_coef_o = rom[re_idx_i];
  assign im_coef_o = rom[im_idx_i];

endmodule

// File: rtl/dft_bin_acc.sv
module dft_bin_acc #(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int SLOT_W = $clog2(N),
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + SLOT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic        [SLOT_W-1:0] slot_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]  acc_o
);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] hist_q [N];
  logic signed [ACC_W-1:0]  acc_q;

  assign prod = sample_i * coef_i;

  // running sum: add newest product, drop the one from a cycle ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      for (int i = 0; i < N; i++) hist_q[i] <= '0;
    end else if (en_i) begin
      acc_q          <= acc_q + ACC_W'(prod) - ACC_W'(hist_q[slot_i]);
      hist_q[slot_i] <= prod;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/dft_seq.sv
module dft_seq #(
  parameter int N   = 16,
  parameter int DEC = 4,
  localparam int SLOT_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              emit_o
);

  logic [SLOT_W-1:0] slot_q;
  logic              filled_q;
  logic              at_dec;

  assign at_dec = (32'(slot_q) % DEC) == (DEC - 1);
  assign emit_o = en_i && at_dec && (filled_q || (32'(slot_q) == N - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      filled_q <= 1'b0;
    end else if (en_i) begin
      slot_q <= (32'(slot_q) == N - 1) ? '0 : slot_q + 1'b1;
      if (32'(slot_q) == N - 1) filled_q <= 1'b1;
    end
  end

endmodule

// File: rtl/phasor_dft_est.sv
module phasor_dft_est #(
  parameter int N      = 16,
  parameter int DEC    = 4,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14,
  localparam int SLOT_W = $clog2(N),
  localparam int PH_W   = DATA_W + COEF_W,
  localparam int ACC_W  = PH_W + SLOT_W,
  localparam int MAG_W  = 2 * PH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic                    phasor_valid_o,
  output logic signed [PH_W-1:0]  re_o,
  output logic signed [PH_W-1:0]  im_o,
  output logic        [MAG_W-1:0] mag_sq_o
);

  logic [SLOT_W-1:0]        slot;
  logic [SLOT_W-1:0]        slot_im;
  logic                     emit;
  logic                     emit_q;
  logic signed [COEF_W-1:0] coef [2];
  logic signed [ACC_W-1:0]  acc  [2];
  logic signed [PH_W-1:0]   ph_re, ph_im;
  logic signed [MAG_W-1:0]  re_w, im_w;

  dft_seq #(.N(N), .DEC(DEC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sample_valid_i),
    .slot_o (slot),
    .emit_o (emit)
  );

  // -sin(a) = cos(a + quarter cycle)
  assign slot_im = slot + SLOT_W'(N / 4);

  dft_coef_rom #(.N(N), .COEF_W(COEF_W), .FRAC(FRAC)) u_rom (
    .re_idx_i  (slot),
    .im_idx_i  (slot_im),
    .re_coef_o (coef[0]),
    .im_coef_o (coef[1])
  );

  for (genvar b = 0; b < 2; b++) begin : g_bin
    dft_bin_acc #(.N(N), .DATA_W(DATA_W), .COEF_W(COEF_W)) u_bin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (sample_valid_i),
      .slot_i   (slot),
      .sample_i (sample_i),
      .coef_i   (coef[b]),
      .acc_o    (acc[b])
    );
  end

  // divide by N (floor)
  assign ph_re = PH_W'(acc[0] >>> SLOT_W);
  assign ph_im = PH_W'(acc[1] >>> SLOT_W);
  assign re_w  = MAG_W'(ph_re);
  assign im_w  = MAG_W'(ph_im);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      emit_q         <= 1'b0;
      phasor_valid_o <= 1'b0;
      re_o           <= '0;
      im_o           <= '0;
      mag_sq_o       <= '0;
    end else begin
      emit_q         <= emit;
      phasor_valid_o <= emit_q;
      if (emit_q) begin
        re_o     <= ph_re;
        im_o     <= ph_im;
        mag_sq_o <= MAG_W'(re_w * re_w + im_w * im_w);
      end
    end
  end

endmodule

// File: rtl/phasor_dft_est_chk.sv
module phasor_dft_est_chk #(
  parameter int N    = 16,
  parameter int DEC  = 4,
  parameter int PH_W = 32,
  localparam int MAG_W = 2 * PH_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sample_valid_i,
  input logic                   phasor_valid_o,
  input logic signed [PH_W-1:0] re_o,
  input logic signed [PH_W-1:0] im_o,
  input logic       [MAG_W-1:0] mag_sq_o
);

  int seen_q;
  int ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 0;
      ph_q   <= 0;
    end else if (sample_valid_i) begin
      if (seen_q < N) seen_q <= seen_q + 1;
      ph_q <= (ph_q == DEC - 1) ? 0 : ph_q + 1;
    end
  end

  p_no_early_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phasor_valid_o |-> $past(seen_q) == N);

  p_decim_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phasor_valid_o |-> $past(ph_q) == 0);

  p_follows_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phasor_valid_o |-> $past(sample_valid_i, 2));

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phasor_valid_o && DEC > 1) |=> !phasor_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phasor_valid_o |-> ($stable(re_o) && $stable(im_o) && $stable(mag_sq_o)));

endmodule

bind phasor_dft_est phasor_dft_est_chk #(.N(N), .DEC(DEC), .PH_W(PH_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .phasor_valid_o (phasor_valid_o),
  .re_o           (re_o),
  .im_o           (im_o),
  .mag_sq_o       (mag_sq_o)
);

// File: tb/tb_phasor_dft_est.sv
module tb_phasor_dft_est;

  localparam int NV = 8;
  // kind: 0 dc, 1 cos, 2 sin, 3 third harmonic, 4 impulse at j=5, 5 alternating
  localparam int VEC_KIND [NV] = '{0, 1, 2, 3, 4, 4, 5, 0};
  localparam int VEC_AMP  [NV] = '{1000, 20000, 20000, 15000, 32767, -32768, 30000, -32768};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [15:0] sample = '0;
  logic        phasor_valid;
  logic [31:0] re, im;
  logic [63:0] mag;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint win [16];
  int     n_acc;
  logic   exp_v;
  longint exp_re, exp_im, exp_mag;

  always #2 clk = ~clk;

  phasor_dft_est dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_valid_i (sample_valid),
    .sample_i       (sample),
    .phasor_valid_o (phasor_valid),
    .re_o           (re),
    .im_o           (im),
    .mag_sq_o       (mag)
  );

  function automatic longint cval(input int k);
    int q [5] = '{23170, 21407, 16384, 8867, 0};
    int m = ((k % 16) + 16) % 16;
    if (m <= 4)  return q[m];
    if (m <= 8)  return -q[8 - m];
    if (m <= 12) return -q[m - 8];
    return q[16 - m];
  endfunction

  function automatic int gen(input int kind, input int amp, input int j);
    case (kind)
      0: return amp;
      1: return int'((longint'(amp) * cval(j)) / 23170);
      2: return int'((longint'(amp) * cval(j + 12)) / 23170);
      3: return int'((longint'(amp) * cval(3 * j)) / 23170);
      4: return (j == 5) ? amp : 0;
      default: return (j % 2) ? -amp : amp;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) win[i] = 0;
    n_acc = 0; exp_v = 0; exp_re = 0; exp_im = 0; exp_mag = 0;
  endtask

  // direct 16-term correlation per R2/R3/R4/R5
  task automatic model_add(input int x);
    longint sr, si;
    win[n_acc % 16] = longint'(x);
    n_acc++;
    exp_v = (n_acc >= 16) && (n_acc % 4 == 0);
    if (exp_v) begin
      sr = 0; si = 0;
      for (int k = 0; k < 16; k++) begin
        sr += win[k] * cval(k);
        si += win[k] * cval(k + 4);
      end
      exp_re  = sr >>> 4;
      exp_im  = si >>> 4;
      exp_mag = exp_re * exp_re + exp_im * exp_im;
    end
  endtask

  task automatic check_out(input string req);
    chk(phasor_valid == exp_v, "R6 R7 valid", longint'(phasor_valid), longint'(exp_v));
    chk($signed(re) == exp_re, {req, " R2 re"}, longint'($signed(re)), exp_re);
    chk($signed(im) == exp_im, {req, " R3 im"}, longint'($signed(im)), exp_im);
    chk(mag == 64'(exp_mag), {req, " R5 mag"}, longint'(mag), exp_mag);
  endtask

  task automatic push(input int x, input string req);
    @(negedge clk);
    sample_valid = 1'b1;
    sample = 16'(x);
    @(negedge clk);
    sample_valid = 1'b0;
    model_add(x);
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phasor_valid == 0 && re == 0 && im == 0 && mag == 0, "R1 reset", longint'(phasor_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phasor_valid == 0 && re == 0 && im == 0 && mag == 0, "R1 after release", longint'(re), 0);

    // table walk: each pattern streams through the sliding window (R4)
    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < 16; j++) push(gen(VEC_KIND[v], VEC_AMP[v], j), "R4 R10");
      if (VEC_KIND[v] == 0) begin
        chk($signed(re) == 0, "R9 dc re", longint'($signed(re)), 0);
        chk($signed(im) == 0, "R9 dc im", longint'($signed(im)), 0);
      end
    end

    // R8: idle cycles with a changing sample are ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sample = 16'(12345 + i * 777);
      chk(phasor_valid == 0, "R8 idle valid", longint'(phasor_valid), 0);
      chk($signed(re) == exp_re, "R8 idle hold", longint'($signed(re)), exp_re);
    end
    for (int j = 0; j < 4; j++) push(gen(1, 9000, j), "R8 after idle");

    // back-to-back strobes: 16 consecutive samples
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      sample_valid = 1'b1;
      sample = 16'(gen(2, -25000, j));
      model_add(gen(2, -25000, j));
    end
    @(negedge clk);
    sample_valid = 1'b0;
    @(negedge clk);
    check_out("R6 burst");

    // mid-stream reset: R1 then R7 fill delay
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(phasor_valid == 0 && re == 0 && im == 0 && mag == 0, "R1 mid reset", longint'(re), 0);
    rst_n = 1'b1;
    model_reset();
    for (int j = 0; j < 20; j++) push(gen(5, 32767, j), "R7 refill");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule